// File: doc/BRIEF.md
# Load-Use Hazard Detector

This block sits beside the decode stage of a five-stage in-order pipeline. It watches the instruction currently in execute and the one currently in decode. When the execute-stage instruction is a memory load and its destination register is one of the registers the decode-stage instruction reads, the loaded value cannot yet be forwarded in time. The block then holds the program counter and the fetch/decode pipeline register for that cycle, and it tells the execute-stage control mux to pass all-zero control bits, which turns the slot into a do-nothing operation.

The detector is purely combinational. Its outputs follow the current inputs in the same cycle. On the next clock the load has moved on to the memory stage, so the condition drops by itself. A single bubble is enough, because writeback forwarding then delivers the loaded data. All ports are plain control pins. No data stream passes through the block, so it has no valid/ready handshake. Register zero is hard-wired to zero and never counts as a dependency.

Top module: `load_use_detect`

## Requirements
- R1: When `ex_mem_read` is 1, `ex_dest` is nonzero and `ex_dest` equals `id_src_a`, a stall is raised. A stall means `pc_write_en`=0, `ifid_write_en`=0 and `ctrl_zero_sel`=1.
- R2: When `ex_mem_read` is 1, `ex_dest` is nonzero and `ex_dest` equals `id_src_b`, a stall is raised.
- R3: When `ex_mem_read` is 0, no stall is raised, whatever the register indices are.
- R4: When `ex_dest` differs from both decode sources, no stall is raised, even for a load.
- R5: A load whose `ex_dest` is register 0 never raises a stall, even when a decode source is also 0.
- R6: `pc_write_en` is 0 during a stall and 1 otherwise.
- R7: `ifid_write_en` is 0 during a stall and 1 otherwise.
- R8: `ctrl_zero_sel` is 1 during a stall and 0 otherwise.
- R9: When both decode sources match the load destination, the outputs are the same single stall as in R1.
- R10: The outputs depend only on the present inputs and hold no state. A dependent load followed by a cycle in which the load has left execute gives exactly one stall cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_mem_read | input | 1 | Execute-stage instruction reads memory |
| ex_dest | input | REG_AW | Destination register index of the execute-stage instruction |
| id_src_a | input | REG_AW | First source register index of the decode-stage instruction |
| id_src_b | input | REG_AW | Second source register index of the decode-stage instruction |
| pc_write_en | output | 1 | 1 lets the program counter advance, 0 holds it |
| ifid_write_en | output | 1 | 1 lets the fetch/decode register load, 0 holds it |
| ctrl_zero_sel | output | 1 | 1 forces the execute-stage control bits to zero |

## Verification
Every result of this block is due in the same cycle as the stimulus, with no register in the path. The bench therefore drives the stage fields just after a falling clock edge and samples all three outputs one nanosecond later, well before the next rising edge. For the one-cycle-stall property, the bench moves the load out of execute at the next clock and checks that the outputs return to the run state in that new cycle.

// File: rtl/lu_pkg.sv
package lu_pkg;
  // Steering bundle produced for the front of the pipeline
  typedef struct packed {
    logic pc_we;    // program counter may advance
    logic fd_we;    // fetch/decode register may load
    logic bubble;   // zero the execute-stage control bits
  } lu_steer_t;

  localparam lu_steer_t LU_RUN  = '{pc_we: 1'b1, fd_we: 1'b1, bubble: 1'b0};
  localparam lu_steer_t LU_HOLD = '{pc_we: 1'b0, fd_we: 1'b0, bubble: 1'b1};
endpackage

// File: rtl/lu_operand_match.sv
module lu_operand_match #(
  parameter int unsigned REG_AW    = 5,
  parameter bit          ZERO_WIRED = 1'b1
) (
  input  logic [REG_AW-1:0] load_dest,
  input  logic [REG_AW-1:0] use_src,
  output logic              hit
);
  logic same_idx;
  assign same_idx = (load_dest == use_src);

  generate
    if (ZERO_WIRED) begin : g_guard
      // register zero is constant and never carries a dependency
      assign hit = same_idx && (load_dest != '0);
    end else begin : g_plain
      assign hit = same_idx;
    end
  endgenerate
endmodule

// File: rtl/lu_stall_decide.sv
module lu_stall_decide
  import lu_pkg::*;
#(
  parameter int unsigned NUM_SRC = 2
) (
  input  logic               is_load,
  input  logic [NUM_SRC-1:0] src_hit,
  output lu_steer_t          steer
);
  logic any_hit;
  assign any_hit = |src_hit;

  always_comb begin
    steer = LU_RUN;
    if (is_load && any_hit) begin
      steer = LU_HOLD;
    end
  end
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect
  import lu_pkg::*;
#(
  parameter int unsigned REG_AW     = 5,
  parameter bit          ZERO_WIRED = 1'b1
) (
  input  logic              ex_mem_read,
  input  logic [REG_AW-1:0] ex_dest,
  input  logic [REG_AW-1:0] id_src_a,
  input  logic [REG_AW-1:0] id_src_b,
  output logic              pc_write_en,
  output logic              ifid_write_en,
  output logic              ctrl_zero_sel
);
  localparam int unsigned NUM_SRC = 2;

  logic [REG_AW-1:0]  src_vec [NUM_SRC];
  logic [NUM_SRC-1:0] hit_vec;
  lu_steer_t          steer;

  assign src_vec[0] = id_src_a;
  assign src_vec[1] = id_src_b;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    lu_operand_match #(
      .REG_AW    (REG_AW),
      .ZERO_WIRED(ZERO_WIRED)
    ) u_match (
      .load_dest(ex_dest),
      .use_src  (src_vec[s]),
      .hit      (hit_vec[s])
    );
  end

  lu_stall_decide #(
    .NUM_SRC(NUM_SRC)
  ) u_decide (
    .is_load(ex_mem_read),
    .src_hit(hit_vec),
    .steer  (steer)
  );

  assign pc_write_en   = steer.pc_we;
  assign ifid_write_en = steer.fd_we;
  assign ctrl_zero_sel = steer.bubble;
endmodule

// File: rtl/load_use_detect_chk.sv
module load_use_detect_chk #(
  parameter int unsigned REG_AW = 5
) (
  input logic              ex_mem_read,
  input logic [REG_AW-1:0] ex_dest,
  input logic [REG_AW-1:0] id_src_a,
  input logic [REG_AW-1:0] id_src_b,
  input logic              pc_write_en,
  input logic              ifid_write_en,
  input logic              ctrl_zero_sel
);
  always_comb begin
    if (ex_mem_read && ex_dest != '0 && ex_dest == id_src_a)
      AST_STALL_ON_SRC_A: assert (ctrl_zero_sel);                     // R1
    if (ex_mem_read && ex_dest != '0 && ex_dest == id_src_b)
      AST_STALL_ON_SRC_B: assert (ctrl_zero_sel);                     // R2
    if (!ex_mem_read)
      AST_NO_LOAD_NO_STALL: assert (!ctrl_zero_sel);                  // R3
    if (ex_dest != id_src_a && ex_dest != id_src_b)
      AST_NO_MATCH_NO_STALL: assert (!ctrl_zero_sel);                 // R4
    if (ex_dest == '0)
      AST_ZERO_DEST_NO_STALL: assert (!ctrl_zero_sel);                // R5
    AST_PC_HOLD_WITH_BUBBLE: assert (pc_write_en == !ctrl_zero_sel);  // R6
    AST_IFID_HOLD_WITH_BUBBLE: assert (ifid_write_en == !ctrl_zero_sel); // R7
  end
endmodule

bind load_use_detect load_use_detect_chk #(.REG_AW(REG_AW)) u_chk (
  .ex_mem_read  (ex_mem_read),
  .ex_dest      (ex_dest),
  .id_src_a     (id_src_a),
  .id_src_b     (id_src_b),
  .pc_write_en  (pc_write_en),
  .ifid_write_en(ifid_write_en),
  .ctrl_zero_sel(ctrl_zero_sel)
);

// File: tb/load_use_detect_tb.sv
`timescale 1ns/1ps
module load_use_detect_tb_top;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ex_mem_read;
  logic [AW-1:0] ex_dest, id_src_a, id_src_b;
  logic          pc_write_en, ifid_write_en, ctrl_zero_sel;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  load_use_detect #(.REG_AW(AW), .ZERO_WIRED(1'b1)) dut_i (
    .ex_mem_read  (ex_mem_read),
    .ex_dest      (ex_dest),
    .id_src_a     (id_src_a),
    .id_src_b     (id_src_b),
    .pc_write_en  (pc_write_en),
    .ifid_write_en(ifid_write_en),
    .ctrl_zero_sel(ctrl_zero_sel)
  );

  task automatic drive(input logic rd, input logic [AW-1:0] d,
                       input logic [AW-1:0] a, input logic [AW-1:0] b);
    @(negedge clk);
    ex_mem_read = rd; ex_dest = d; id_src_a = a; id_src_b = b;
    #1;
  endtask

  task automatic expect_stall(input bit stall, input string tag);
    n_checks++;
    if (pc_write_en !== !stall) begin
      n_fail++;
      $display("FAIL %s pc_write_en=%b expected %b", tag, pc_write_en, !stall);
    end
    n_checks++;
    if (ifid_write_en !== !stall) begin
      n_fail++;
      $display("FAIL %s ifid_write_en=%b expected %b", tag, ifid_write_en, !stall);
    end
    n_checks++;
    if (ctrl_zero_sel !== stall) begin
      n_fail++;
      $display("FAIL %s ctrl_zero_sel=%b expected %b", tag, ctrl_zero_sel, stall);
    end
  endtask

  task automatic t_reset_state();
    drive(1'b0, '0, '0, '0);
    expect_stall(1'b0, "R6 R7 R8 idle");
  endtask

  task automatic t_dep_src_a();
    drive(1'b1, 5'd7, 5'd7, 5'd3);
    expect_stall(1'b1, "R1 src_a match");
  endtask

  task automatic t_dep_src_b();
    drive(1'b1, 5'd12, 5'd4, 5'd12);
    expect_stall(1'b1, "R2 src_b match");
  endtask

  task automatic t_both_match();
    drive(1'b1, 5'd31, 5'd31, 5'd31);
    expect_stall(1'b1, "R9 both match");
  endtask

  task automatic t_not_load();
    drive(1'b0, 5'd9, 5'd9, 5'd9);
    expect_stall(1'b0, "R3 non-load match");
  endtask

  task automatic t_independent();
    for (int d = 1; d < 32; d++) begin
      drive(1'b1, AW'(d), AW'((d + 1) % 32), AW'((d + 5) % 32));
      expect_stall(1'b0, "R4 independent");
    end
  endtask

  task automatic t_zero_dest();
    drive(1'b1, 5'd0, 5'd0, 5'd0);
    expect_stall(1'b0, "R5 dest r0");
    drive(1'b1, 5'd0, 5'd0, 5'd6);
    expect_stall(1'b0, "R5 dest r0 src_a r0");
  endtask

  task automatic t_one_cycle();
    drive(1'b1, 5'd2, 5'd2, 5'd8);
    expect_stall(1'b1, "R10 stall cycle");
    // next cycle: load moved to memory stage, an add sits in execute
    drive(1'b0, 5'd4, 5'd2, 5'd8);
    expect_stall(1'b0, "R10 released next cycle");
  endtask

  initial begin
    ex_mem_read = 1'b0; ex_dest = '0; id_src_a = '0; id_src_b = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_dep_src_a();
    t_dep_src_b();
    t_both_match();
    t_not_load();
    t_independent();
    t_zero_dest();
    t_one_cycle();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule